// File: doc/BRIEF.md
# External Interrupt Polarity Normalizer

This block takes three external interrupt pins and turns each into a request that a downstream interrupt controller can accept. That controller understands only active-high levels and rising edges. A line set to active-low level is inverted. A line set to falling edge has its falling transitions caught in a sticky pending latch, and the latch output acts as the rising-edge request. Each pin passes through a two-flop synchronizer before its level is used or its edges are detected.

Software controls every line through an 8-bit control byte. The byte holds the trigger type, an enable, a sampling-rate select and the pending flag. The parameter `SHARED_LAYOUT` selects one of two layouts. In the shared layout, all three bytes sit in one 32-bit register, with byte enables so that one line can be written alone. In the split layout, each byte sits at its own address. When the sampling-rate select is set, the line's synchronizer and edge detector advance only on cycles where `smp_tick` is high. That input is the slower sampling strobe from outside the block.

Top module: `extirq_normalizer`

## Requirements
- R1: There are three lines, numbered 0 to 2. In each control byte, bit 0 is pending, bit 4 is the sampling-rate select, bit 5 is enable, and bits 7:6 are the trigger type (00 high level, 01 low level, 10 rising edge, 11 falling edge). Bits 3:1 read as zero. After reset every byte is zero and every `irq_out` bit is low.
- R2: With `SHARED_LAYOUT`=1 the register is at address 0x000. Line 0 is in bits 23:16, line 1 in bits 15:8 and line 2 in bits 7:0, and bits 31:24 read as zero. A line's byte changes only when its byte enable is set: `reg_be[2]` for line 0, `reg_be[1]` for line 1 and `reg_be[0]` for line 2. One read returns all three bytes.
- R3: With `SHARED_LAYOUT`=0 the bytes of lines 0, 1 and 2 are at addresses 0x000, 0x328 and 0x32C, in bits 7:0. They are written only when `reg_be[0]` is set. Any other address reads as zero and ignores writes.
- R4: In a level mode, `irq_out` equals enable AND (synchronized input XOR bit 6). It changes two clock edges after the pin changes. The pending bit reads this conditioned level.
- R5: In an edge mode, a rising pin transition (type 10) or a falling one (type 11) on an enabled line sets pending. `irq_out` follows pending and rises three clock edges after the pin transition. It stays high after the pin returns to its idle level.
- R6: A register write with bit 0 set clears pending in edge mode, at the clock edge of the write. Writing 0 to bit 0 has no effect. In level modes bit 0 cannot be changed by a write. If an edge is detected on the same cycle as the clearing write, the edge wins.
- R7: While enable is 0, `irq_out` for that line is low and no edge is captured.
- R8: While the sampling-rate select is 1, the line's synchronizer advances only on cycles with `smp_tick` high. A level change therefore needs two ticks to reach `irq_out`.
- R9: A line switched into a level mode drops any edge pending it held. Switching it back to an edge mode does not bring that pending back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | Strobe for the slow sampling rate |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_be | input | DATA_W/8 | Write byte enables |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| ext_in | input | 3 | Raw external interrupt pins |
| irq_out | output | 3 | Normalized requests to the downstream controller |

## Verification
Results become visible at different points:
- A register write takes effect at the clock edge that samples it, and `reg_rdata` is combinational.
- A pin change reaches `irq_out` after two edges in level mode and after three edges in edge mode, counting the ticks instead of edges when the slow sampling rate is selected.

The bench drives every stimulus on a falling edge and samples on a falling edge after an exact count of rising edges. It checks one edge before each result is due, to confirm the output has not yet moved, and then again on the edge where it is due. The sweep covers every trigger type on every line and compares the whole `irq_out` vector, so any crosstalk between lines is also caught.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int unsigned NUM_LINES = 3;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned OFFS_W    = 12;

    typedef enum logic [1:0] {
        TRIG_LEVEL_HIGH = 2'b00,
        TRIG_LEVEL_LOW  = 2'b01,
        TRIG_EDGE_RISE  = 2'b10,
        TRIG_EDGE_FALL  = 2'b11
    } trig_e;

    // Control byte as seen on the register port (bit 7 down to bit 0).
    typedef struct packed {
        trig_e      trig;
        logic       enable;
        logic       slow_clk;
        logic [2:0] rsvd;
        logic       pending;
    } ctl_byte_t;

    // Stored configuration of one line.
    typedef struct packed {
        trig_e trig;
        logic  enable;
        logic  slow_clk;
    } line_cfg_t;

    localparam line_cfg_t CFG_RESET = '{trig: TRIG_LEVEL_HIGH, enable: 1'b0, slow_clk: 1'b0};

    function automatic logic trig_is_edge(trig_e t);
        return (t == TRIG_EDGE_RISE) || (t == TRIG_EDGE_FALL);
    endfunction

    function automatic logic trig_is_inverted(trig_e t);
        return (t == TRIG_LEVEL_LOW) || (t == TRIG_EDGE_FALL);
    endfunction

    // Split-layout address of each line's control byte.
    function automatic logic [OFFS_W-1:0] line_offset(int unsigned idx);
        case (idx)
            0:       return 12'h000;
            1:       return 12'h328;
            default: return 12'h32C;
        endcase
    endfunction

endpackage

// File: rtl/extirq_sampler.sv
module extirq_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_en,
    input  logic raw,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else if (smp_en) begin
            chain <= {chain[STAGES-2:0], raw};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    // Qualified by the sample strobe so a slow window reports each edge once.
    assign rise = smp_en &  lvl & ~prev;
    assign fall = smp_en & ~lvl &  prev;
endmodule

// File: rtl/extirq_line.sv
module extirq_line
    import extirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_tick,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              raw,
    output ctl_byte_t         rbyte,
    output logic              irq,
    output logic              lvl_sync,
    output logic              edge_hit
);
    line_cfg_t cfg_q;
    logic      pend_q;
    ctl_byte_t wr_view;
    logic      smp_en;
    logic      rise;
    logic      fall;
    logic      cond_lvl;
    logic      is_edge;
    logic      wr_unused;

    assign wr_view   = ctl_byte_t'(wbyte);
    assign wr_unused = ^wr_view.rsvd;
    assign smp_en    = ~cfg_q.slow_clk | smp_tick;
    assign is_edge   = trig_is_edge(cfg_q.trig);

    extirq_sampler #(.STAGES(SYNC_STAGES)) i_sampler (
        .clk    (clk),
        .rst    (rst),
        .smp_en (smp_en),
        .raw    (raw),
        .lvl    (lvl_sync),
        .rise   (rise),
        .fall   (fall)
    );

    assign cond_lvl = lvl_sync ^ trig_is_inverted(cfg_q.trig);
    assign edge_hit = cfg_q.enable & is_edge &
                      (trig_is_inverted(cfg_q.trig) ? fall : rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            pend_q <= 1'b0;
        end else begin
            if (wr) begin
                cfg_q <= '{trig: wr_view.trig, enable: wr_view.enable,
                           slow_clk: wr_view.slow_clk};
            end
            if (!is_edge)
                pend_q <= 1'b0;
            else if (edge_hit)
                pend_q <= 1'b1;
            else if (wr && wr_view.pending)
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        rbyte          = '0;
        rbyte.trig     = cfg_q.trig;
        rbyte.enable   = cfg_q.enable;
        rbyte.slow_clk = cfg_q.slow_clk;
        rbyte.pending  = is_edge ? pend_q : cond_lvl;
    end

    assign irq = cfg_q.enable & (is_edge ? pend_q : cond_lvl);
endmodule

// File: rtl/extirq_regif.sv
module extirq_regif
    import extirq_pkg::*;
#(
    parameter bit          SHARED = 1'b1,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [LANES-1:0]                  be,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic [NUM_LINES-1:0][BYTE_W-1:0]  rd_bytes,
    output logic [NUM_LINES-1:0]              line_wr,
    output logic [NUM_LINES-1:0][BYTE_W-1:0]  line_wdata,
    output logic [DATA_W-1:0]                 rdata
);
    generate
        if (SHARED) begin : g_shared
            logic hit;
            logic lane_unused;
            assign hit         = (addr == '0);
            assign lane_unused = ^{be, wdata};
            for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
                localparam int unsigned LANE = NUM_LINES - 1 - i;
                assign line_wr[i]    = we & hit & be[LANE];
                assign line_wdata[i] = wdata[LANE*BYTE_W +: BYTE_W];
            end
            always_comb begin
                rdata = '0;
                if (hit) begin
                    for (int k = 0; k < NUM_LINES; k++)
                        rdata[(NUM_LINES-1-k)*BYTE_W +: BYTE_W] = rd_bytes[k];
                end
            end
        end else begin : g_split
            logic [NUM_LINES-1:0] hit;
            logic                 lane_unused;
            assign lane_unused = ^{be, wdata};
            for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
                assign hit[i]        = (addr == ADDR_W'(line_offset(i)));
                assign line_wr[i]    = we & hit[i] & be[0];
                assign line_wdata[i] = wdata[BYTE_W-1:0];
            end
            always_comb begin
                rdata = '0;
                for (int k = 0; k < NUM_LINES; k++)
                    if (hit[k]) rdata[BYTE_W-1:0] = rd_bytes[k];
            end
        end
    endgenerate
endmodule

// File: rtl/extirq_normalizer.sv
module extirq_normalizer
    import extirq_pkg::*;
#(
    parameter bit          SHARED_LAYOUT = 1'b1,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_tick,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W/8-1:0]  reg_be,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] ext_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0]             line_wr;
    logic [NUM_LINES-1:0][BYTE_W-1:0] line_wdata;
    logic [NUM_LINES-1:0][BYTE_W-1:0] rd_bytes;
    logic [NUM_LINES-1:0]             lvl_sync;
    logic [NUM_LINES-1:0]             edge_hit;

    extirq_regif #(
        .SHARED (SHARED_LAYOUT),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_regif (
        .we         (reg_we),
        .addr       (reg_addr),
        .be         (reg_be),
        .wdata      (reg_wdata),
        .rd_bytes   (rd_bytes),
        .line_wr    (line_wr),
        .line_wdata (line_wdata),
        .rdata      (reg_rdata)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        ctl_byte_t rbyte;
        extirq_line #(.SYNC_STAGES(SYNC_STAGES)) i_line (
            .clk      (clk),
            .rst      (rst),
            .smp_tick (smp_tick),
            .wr       (line_wr[i]),
            .wbyte    (line_wdata[i]),
            .raw      (ext_in[i]),
            .rbyte    (rbyte),
            .irq      (irq_out[i]),
            .lvl_sync (lvl_sync[i]),
            .edge_hit (edge_hit[i])
        );
        assign rd_bytes[i] = rbyte;
    end
endmodule

// File: rtl/extirq_normalizer_chk.sv
module extirq_normalizer_chk
    import extirq_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_LINES-1:0]             line_wr,
    input logic [NUM_LINES-1:0][BYTE_W-1:0] line_wdata,
    input logic [NUM_LINES-1:0][BYTE_W-1:0] rd_bytes,
    input logic [NUM_LINES-1:0]             lvl_sync,
    input logic [NUM_LINES-1:0]             edge_hit,
    input logic [NUM_LINES-1:0]             irq_out
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        // R7: a disabled line never requests
        a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
            !rd_bytes[i][5] |-> !irq_out[i]);

        // R4: level mode output tracks the synchronized pin with polarity applied
        a_r4_level_tracks: assert property (@(posedge clk) disable iff (rst)
            (!rd_bytes[i][7] && rd_bytes[i][5]) |-> (irq_out[i] == (lvl_sync[i] ^ rd_bytes[i][6])));

        // R5: an edge request holds until software writes the line
        a_r5_edge_sticky: assert property (@(posedge clk) disable iff (rst)
            (rd_bytes[i][7] && irq_out[i] && !line_wr[i]) |=> irq_out[i]);

        // R6: a clearing write in edge mode drops the request when no edge competes
        a_r6_w1c_clears: assert property (@(posedge clk) disable iff (rst)
            (rd_bytes[i][7] && line_wr[i] && line_wdata[i][0] && line_wdata[i][7] && !edge_hit[i])
            |=> !irq_out[i]);

        // R2: configuration bits change only on a write to that line
        a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
            !line_wr[i] |=> (rd_bytes[i][7:4] == $past(rd_bytes[i][7:4])));
    end
endmodule

bind extirq_normalizer extirq_normalizer_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .line_wr    (line_wr),
    .line_wdata (line_wdata),
    .rd_bytes   (rd_bytes),
    .lvl_sync   (lvl_sync),
    .edge_hit   (edge_hit),
    .irq_out    (irq_out)
);

// File: tb/test_extirq_normalizer.sv
module test_extirq_normalizer;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;

    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  ext = '0;
    logic [2:0]  irq;

    logic        s_we = 1'b0;
    logic [11:0] s_addr = '0;
    logic [3:0]  s_be = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic [2:0]  s_ext = '0;
    logic [2:0]  s_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extirq_normalizer #(.SHARED_LAYOUT(1'b1)) i_extirq_normalizer (
        .clk(clk), .rst(rst), .smp_tick(tick), .reg_we(we), .reg_addr(addr),
        .reg_be(be), .reg_wdata(wdata), .reg_rdata(rdata), .ext_in(ext), .irq_out(irq)
    );

    extirq_normalizer #(.SHARED_LAYOUT(1'b0)) i_extirq_normalizer_split (
        .clk(clk), .rst(rst), .smp_tick(tick), .reg_we(s_we), .reg_addr(s_addr),
        .reg_be(s_be), .reg_wdata(s_wdata), .reg_rdata(s_rdata), .ext_in(s_ext), .irq_out(s_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_sh(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
        addr = a; be = b; wdata = d; we = 1'b1;
        step(1);
        we = 1'b0; be = '0;
    endtask

    task automatic wr_sp(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
        s_addr = a; s_be = b; s_wdata = d; s_we = 1'b1;
        step(1);
        s_we = 1'b0; s_be = '0;
    endtask

    task automatic rd_sh(input logic [11:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic rd_sp(input logic [11:0] a, output logic [31:0] d);
        s_addr = a; #1; d = s_rdata;
    endtask

    function automatic logic [7:0] cb(input logic [1:0] t, input logic en,
                                      input logic slow, input logic clr);
        return {t, en, slow, 3'b000, clr};
    endfunction

    // Write one line's byte in the shared layout (line 0 in lane 2, line 2 in lane 0).
    task automatic wr_line(input int line, input logic [7:0] b);
        wr_sh(12'h000, 4'b0001 << (2 - line), 32'(b) << (8 * (2 - line)));
    endtask

    task automatic pend_of(input int line, output logic p);
        logic [31:0] d;
        rd_sh(12'h000, d);
        p = d[8*(2-line)];
    endtask

    task automatic run_case(input int line, input logic [1:0] t);
        logic       ina;
        logic       p;
        logic [2:0] one;
        ina = t[0];
        one = 3'b001 << line;
        ext[line] = ina;
        step(4);
        wr_line(line, cb(t, 1'b1, 1'b0, 1'b1));
        check(t[1] ? "R5 idle" : "R4 idle", 32'(irq), 32'(3'b000));
        ext[line] = ~ina;
        step(1);
        check(t[1] ? "R5 early" : "R4 early", 32'(irq), 32'(3'b000));
        if (!t[1]) begin
            step(1);
            check("R4 asserted after 2 edges", 32'(irq), 32'(one));
            pend_of(line, p);
            check("R4 pending shows level", 32'(p), 32'(1));
            wr_line(line, cb(t, 1'b1, 1'b0, 1'b1));
            check("R6 level not clearable", 32'(irq), 32'(one));
            ext[line] = ina;
            step(2);
            check("R4 deasserted", 32'(irq), 32'(3'b000));
        end else begin
            step(1);
            check("R5 not before 3 edges", 32'(irq), 32'(3'b000));
            step(1);
            check("R5 asserted after 3 edges", 32'(irq), 32'(one));
            ext[line] = ina;
            step(3);
            check("R5 sticky", 32'(irq), 32'(one));
            wr_line(line, cb(t, 1'b1, 1'b0, 1'b0));
            check("R6 write zero keeps", 32'(irq), 32'(one));
            wr_line(line, cb(t, 1'b1, 1'b0, 1'b1));
            check("R6 write one clears", 32'(irq), 32'(3'b000));
            pend_of(line, p);
            check("R6 pending reads zero", 32'(p), 32'(0));
        end
        wr_line(line, 8'h00);
        ext[line] = 1'b0;
        step(3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        p;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        check("R1 reset irq", 32'(irq), 32'(0));
        rd_sh(12'h000, d);
        check("R1 reset register", d, 32'h0);
        rd_sp(12'h328, d);
        check("R1 reset split register", d, 32'h0);

        // R2 packing, reserved bits, polarity R4 right after config
        wr_sh(12'h000, 4'b1111, 32'hFF61_BF0E);
        rd_sh(12'h000, d);
        check("R2 packed readback", d, 32'h0061_B000);
        check("R4 low-active idle pin requests", 32'(irq), 32'(3'b001));
        wr_sh(12'h000, 4'b0010, 32'hFFFF_00FF);
        rd_sh(12'h000, d);
        check("R2 single lane write", d, 32'h0061_0000);
        wr_sh(12'h000, 4'b0111, 32'h0);
        step(2);

        // Sweep of every trigger type on every line (R4 R5 R6)
        for (int line = 0; line < 3; line++)
            for (int t = 0; t < 4; t++)
                run_case(line, 2'(t));

        // R7 disabled edge line captures nothing
        wr_line(0, cb(2'b10, 1'b0, 1'b0, 1'b1));
        ext[0] = 1'b1;
        step(4);
        check("R7 disabled irq low", 32'(irq), 32'(0));
        pend_of(0, p);
        check("R7 no capture while disabled", 32'(p), 32'(0));
        wr_line(0, cb(2'b10, 1'b1, 1'b0, 1'b0));
        step(2);
        check("R7 no stale capture on enable", 32'(irq), 32'(0));
        wr_line(0, cb(2'b00, 1'b0, 1'b0, 1'b0));
        step(1);
        check("R7 disabled level line low", 32'(irq), 32'(0));
        ext[0] = 1'b0;
        step(3);

        // R9 switching to level mode drops pending
        wr_line(1, cb(2'b10, 1'b1, 1'b0, 1'b1));
        ext[1] = 1'b1;
        step(3);
        check("R9 captured first", 32'(irq), 32'(3'b010));
        ext[1] = 1'b0;
        step(3);
        wr_line(1, cb(2'b00, 1'b1, 1'b0, 1'b0));
        check("R9 level mode low", 32'(irq), 32'(0));
        wr_line(1, cb(2'b10, 1'b1, 1'b0, 1'b0));
        check("R9 pending gone after return", 32'(irq), 32'(0));
        wr_line(1, 8'h00);

        // R8 slow sampling gated by tick
        wr_line(2, cb(2'b00, 1'b1, 1'b1, 1'b0));
        ext[2] = 1'b1;
        step(6);
        check("R8 no tick no change", 32'(irq), 32'(0));
        tick = 1'b1; step(1); tick = 1'b0;
        check("R8 one tick not enough", 32'(irq), 32'(0));
        step(3);
        check("R8 still waiting", 32'(irq), 32'(0));
        tick = 1'b1; step(1); tick = 1'b0;
        check("R8 second tick delivers", 32'(irq), 32'(3'b100));
        wr_line(2, 8'h00);
        ext[2] = 1'b0;

        // R3 split layout
        wr_sp(12'h328, 4'b0001, 32'hFFFF_FF60);
        rd_sp(12'h328, d);
        check("R3 line 1 at 0x328", d, 32'h0000_0061);
        rd_sp(12'h000, d);
        check("R3 line 0 untouched", d, 32'h0);
        rd_sp(12'h32C, d);
        check("R3 line 2 untouched", d, 32'h0);
        check("R3 split irq", 32'(s_irq), 32'(3'b010));
        wr_sp(12'h32C, 4'b1110, 32'h0000_00A0);
        rd_sp(12'h32C, d);
        check("R3 lane 0 required", d, 32'h0);
        wr_sp(12'h004, 4'b0001, 32'h0000_0060);
        rd_sp(12'h004, d);
        check("R3 unmapped reads zero", d, 32'h0);
        rd_sp(12'h000, d);
        check("R3 unmapped write ignored", d, 32'h0);
        wr_sp(12'h32C, 4'b0001, 32'(cb(2'b10, 1'b1, 1'b0, 1'b1)));
        s_ext[2] = 1'b1;
        step(3);
        check("R3 split edge line 2", 32'(s_irq), 32'(3'b110));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule